// File: doc/BRIEF.md
# CAN Controller Interrupt Collector

This block sits beside a CAN protocol core and condenses its event and status signals into a nine-bit interrupt status word, with one enable bit per source, and a single interrupt request line. Each source has its own trigger rule. The receive source follows the level of the receive-FIFO-not-empty signal. The transmit-buffer-released and data-overrun statuses trigger on their rising edge. The warning and bus-off statuses trigger on any change of either signal. The error-passive state triggers on entry and on exit. The arbitration-lost, bus-error, timestamp-overflow and idle-detect inputs are single-cycle pulses.

A small register port gives the host access. Address 0 returns the status word, and reading it clears every latched source. Address 1 is the enable word, which the host can both read and write. The request line is high whenever any status bit is set.

Top module: `can_irq_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status word, the enable word and `irqOut` are all zero.
- R2: Status bit 0 (receive) equals `rxPending` AND enable bit 0 in the same cycle. A status read does not clear it.
- R3: Status bit 1 (transmit) sets in the cycle after `txReleased` goes from 0 to 1. A 1-to-0 change does not set it.
- R4: Status bit 2 (warning) sets in the cycle after any change, rising or falling, of `warnStatus` or `busOffStatus`.
- R5: Status bit 3 (overrun) sets in the cycle after `overrunStatus` rises. A falling change does not set it.
- R6: Status bit 5 (error-passive) sets in the cycle after `errPassive` changes in either direction.
- R7: A one-cycle pulse on `tsOvflPulse`, `arbLostPulse`, `busErrPulse` or `idlePulse` sets status bit 4, 6, 7 or 8 respectively in the next cycle.
- R8: An event that arrives while its enable bit is 0 does not set its status bit, and enabling the source afterwards does not set it later.
- R9: A read at address 0 (`regRdEn`=1, `regAddr`=0) returns the status word in the same cycle and clears bits 1 to 8 from the next cycle.
- R10: `irqOut` is 1 exactly when at least one status bit is 1.
- R11: If an enabled event and a status read fall in the same cycle, the read returns the old word, and the event's bit is set afterwards.
- R12: A write at address 1 (`regWrEn`=1) loads `regWrData` into the enable word. It reads back at address 1 and takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxPending | input | 1 | Receive FIFO holds at least one message |
| txReleased | input | 1 | Transmit buffer released status |
| warnStatus | input | 1 | Error counters at or above warning limit |
| busOffStatus | input | 1 | Node is bus-off |
| overrunStatus | input | 1 | Data overrun status |
| errPassive | input | 1 | Node is error-passive |
| arbLostPulse | input | 1 | Arbitration lost, one-cycle pulse |
| busErrPulse | input | 1 | Bus error detected, one-cycle pulse |
| tsOvflPulse | input | 1 | Timestamp counter overflow, one-cycle pulse |
| idlePulse | input | 1 | Idle detected, one-cycle pulse |
| regAddr | input | 1 | 0 selects the status word, 1 selects the enable word |
| regRdEn | input | 1 | Read strobe |
| regWrEn | input | 1 | Write strobe (applies to the enable word only) |
| regWrData | input | 9 | Write data |
| regRdData | output | 9 | Read data, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The clearing read and a new enabled event can land in the same clock cycle. If the clear won, that event would be lost without trace.

The bench provokes the collision by raising an event pulse in the same cycle as the status read, after first latching a different source. It expects two results. The read must return only the earlier source. The following read must show the colliding source still set, while the earlier one is gone.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int NUM_SRC = 9;

  localparam int BIT_RX      = 0;
  localparam int BIT_TX      = 1;
  localparam int BIT_WARN    = 2;
  localparam int BIT_OVERRUN = 3;
  localparam int BIT_TSOVFL  = 4;
  localparam int BIT_PASSIVE = 5;
  localparam int BIT_ARBLOST = 6;
  localparam int BIT_BUSERR  = 7;
  localparam int BIT_IDLE    = 8;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  typedef enum logic [2:0] {
    TRIG_LEVEL,
    TRIG_RISE,
    TRIG_TOGGLE,
    TRIG_TOGGLE_PAIR,
    TRIG_PULSE
  } trigKind_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] hit;
    logic               rdClear;
    logic               enWrite;
  } irqStrobe_t;

  function automatic trigKind_e kindOf(int idx);
    case (idx)
      BIT_RX:      return TRIG_LEVEL;
      BIT_TX:      return TRIG_RISE;
      BIT_WARN:    return TRIG_TOGGLE_PAIR;
      BIT_OVERRUN: return TRIG_RISE;
      BIT_PASSIVE: return TRIG_TOGGLE;
      default:     return TRIG_PULSE;
    endcase
  endfunction

endpackage

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcVec,
  input  logic               pairIn,
  input  logic               regAddr,
  input  logic               regRdEn,
  input  logic               regWrEn,
  output irqStrobe_t         strobe
);

  logic [NUM_SRC-1:0] hitVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam trigKind_e KIND = kindOf(i);
    if (KIND == TRIG_LEVEL || KIND == TRIG_PULSE) begin : g_direct
      assign hitVec[i] = srcVec[i];
    end else if (KIND == TRIG_RISE) begin : g_rise
      logic prevQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= srcVec[i];
      end
      assign hitVec[i] = srcVec[i] & ~prevQ;
    end else if (KIND == TRIG_TOGGLE) begin : g_toggle
      logic prevQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= srcVec[i];
      end
      assign hitVec[i] = srcVec[i] ^ prevQ;
    end else begin : g_pair
      logic prevQ;
      logic prevPairQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ     <= 1'b0;
          prevPairQ <= 1'b0;
        end else begin
          prevQ     <= srcVec[i];
          prevPairQ <= pairIn;
        end
      end
      assign hitVec[i] = (srcVec[i] ^ prevQ) | (pairIn ^ prevPairQ);
    end
  end

  always_comb begin
    strobe.hit     = hitVec;
    strobe.rdClear = regRdEn && (regAddr == ADDR_STATUS);
    strobe.enWrite = regWrEn && (regAddr == ADDR_ENABLE);
  end

endmodule

// File: rtl/can_irq_dp.sv
module can_irq_dp
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic               regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] statusWord,
  output logic [NUM_SRC-1:0] enWord,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enWord <= '0;
    else if (strobe.enWrite) enWord <= regWrData;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (kindOf(i) == TRIG_LEVEL) begin : g_level
      assign statusWord[i] = strobe.hit[i] & enWord[i];
    end else begin : g_latch
      logic stickyQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          stickyQ <= 1'b0;
        else if (strobe.hit[i] && enWord[i]) stickyQ <= 1'b1;
        else if (strobe.rdClear)            stickyQ <= 1'b0;
      end
      assign statusWord[i] = stickyQ;
    end
  end

  assign regRdData = (regAddr == ADDR_ENABLE) ? enWord : statusWord;
  assign irqOut    = |statusWord;

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxPending,
  input  logic               txReleased,
  input  logic               warnStatus,
  input  logic               busOffStatus,
  input  logic               overrunStatus,
  input  logic               errPassive,
  input  logic               arbLostPulse,
  input  logic               busErrPulse,
  input  logic               tsOvflPulse,
  input  logic               idlePulse,
  input  logic               regAddr,
  input  logic               regRdEn,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_SRC-1:0] statusWord;
  logic [NUM_SRC-1:0] enWord;
  irqStrobe_t         strobe;

  always_comb begin
    srcVec              = '0;
    srcVec[BIT_RX]      = rxPending;
    srcVec[BIT_TX]      = txReleased;
    srcVec[BIT_WARN]    = warnStatus;
    srcVec[BIT_OVERRUN] = overrunStatus;
    srcVec[BIT_TSOVFL]  = tsOvflPulse;
    srcVec[BIT_PASSIVE] = errPassive;
    srcVec[BIT_ARBLOST] = arbLostPulse;
    srcVec[BIT_BUSERR]  = busErrPulse;
    srcVec[BIT_IDLE]    = idlePulse;
  end

  can_irq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .srcVec  (srcVec),
    .pairIn  (busOffStatus),
    .regAddr (regAddr),
    .regRdEn (regRdEn),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  can_irq_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .statusWord (statusWord),
    .enWord     (enWord),
    .regRdData  (regRdData),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk
  import can_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               rxPending,
  input logic               txReleased,
  input logic               busErrPulse,
  input logic               regAddr,
  input logic               regRdEn,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusWord,
  input logic [NUM_SRC-1:0] enWord
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (statusWord == '0 && enWord == '0 && !irqOut));

  assert_rx_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rxPending && enWord[BIT_RX]) |-> (statusWord[BIT_RX] && irqOut));

  assert_tx_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enWord[BIT_TX] && txReleased && !$past(txReleased)) |=> statusWord[BIT_TX]);

  assert_disabled_stays_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enWord[BIT_BUSERR] && !statusWord[BIT_BUSERR]) |=> !statusWord[BIT_BUSERR]);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_STATUS && !busErrPulse) |=> !statusWord[BIT_BUSERR]);

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_STATUS && busErrPulse && enWord[BIT_BUSERR])
      |=> statusWord[BIT_BUSERR]);

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut) |-> !(rxPending && enWord[BIT_RX]));

endmodule

bind can_irq_unit can_irq_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .rxPending   (rxPending),
  .txReleased  (txReleased),
  .busErrPulse (busErrPulse),
  .regAddr     (regAddr),
  .regRdEn     (regRdEn),
  .irqOut      (irqOut),
  .statusWord  (statusWord),
  .enWord      (enWord)
);

// File: tb/can_irq_unit_tb_top.sv
module can_irq_unit_tb_top;
  import can_irq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxPending = 1'b0, txReleased = 1'b0, warnStatus = 1'b0, busOffStatus = 1'b0;
  logic overrunStatus = 1'b0, errPassive = 1'b0;
  logic arbLostPulse = 1'b0, busErrPulse = 1'b0, tsOvflPulse = 1'b0, idlePulse = 1'b0;
  logic regAddr = 1'b0, regRdEn = 1'b0, regWrEn = 1'b0;
  logic [NUM_SRC-1:0] regWrData = '0;
  logic [NUM_SRC-1:0] regRdData;
  logic irqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  can_irq_unit dut_i (.*);

  task automatic checkEq(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // All tasks are entered right after a falling edge and return right after one.
  task automatic readReg(input logic addr, output logic [NUM_SRC-1:0] data);
    regAddr = addr;
    regRdEn = 1'b1;
    #1 data = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeEn(input logic [NUM_SRC-1:0] val);
    regAddr   = ADDR_ENABLE;
    regWrEn   = 1'b1;
    regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic expectStatus(string tag, int expected);
    logic [NUM_SRC-1:0] d;
    readReg(ADDR_STATUS, d);
    checkEq(tag, int'(d), expected);
  endtask

  task automatic testReset();
    logic [NUM_SRC-1:0] d;
    checkEq("R1 irq after reset", int'(irqOut), 0);
    readReg(ADDR_ENABLE, d);
    checkEq("R1 enable after reset", int'(d), 0);
    expectStatus("R1 status after reset", 0);
  endtask

  task automatic testEnable();
    logic [NUM_SRC-1:0] d;
    writeEn(9'h0A5);
    readReg(ADDR_ENABLE, d);
    checkEq("R12 enable readback", int'(d), 9'h0A5);
    writeEn(9'h1FF);
    readReg(ADDR_ENABLE, d);
    checkEq("R12 enable readback all", int'(d), 9'h1FF);
  endtask

  task automatic testRx();
    rxPending = 1'b1;
    settle();
    checkEq("R10 irq with rx level", int'(irqOut), 1);
    expectStatus("R2 rx level", 9'h001);
    expectStatus("R2 rx not cleared by read", 9'h001);
    rxPending = 1'b0;
    #1 checkEq("R10 irq drops with rx level", int'(irqOut), 0);
    settle();
    expectStatus("R2 rx follows level", 0);
  endtask

  task automatic testTx();
    txReleased = 1'b1;
    settle();
    expectStatus("R3 tx rise", 9'h002);
    expectStatus("R9 tx cleared by read", 0);
    txReleased = 1'b0;
    settle();
    expectStatus("R3 tx fall ignored", 0);
  endtask

  task automatic testWarn();
    warnStatus = 1'b1;
    settle();
    expectStatus("R4 warning rise", 9'h004);
    warnStatus = 1'b0;
    settle();
    expectStatus("R4 warning fall", 9'h004);
    busOffStatus = 1'b1;
    settle();
    expectStatus("R4 bus-off rise", 9'h004);
    busOffStatus = 1'b0;
    settle();
    expectStatus("R4 bus-off fall", 9'h004);
  endtask

  task automatic testOverrun();
    overrunStatus = 1'b1;
    settle();
    expectStatus("R5 overrun rise", 9'h008);
    overrunStatus = 1'b0;
    settle();
    expectStatus("R5 overrun fall ignored", 0);
  endtask

  task automatic testPassive();
    errPassive = 1'b1;
    settle();
    expectStatus("R6 enter passive", 9'h020);
    errPassive = 1'b0;
    settle();
    expectStatus("R6 return active", 9'h020);
  endtask

  task automatic testPulses();
    tsOvflPulse = 1'b1; settle(); tsOvflPulse = 1'b0;
    expectStatus("R7 timestamp overflow", 9'h010);
    arbLostPulse = 1'b1; settle(); arbLostPulse = 1'b0;
    expectStatus("R7 arbitration lost", 9'h040);
    busErrPulse = 1'b1; settle(); busErrPulse = 1'b0;
    checkEq("R10 irq after pulse", int'(irqOut), 1);
    expectStatus("R7 bus error", 9'h080);
    checkEq("R10 irq after clear", int'(irqOut), 0);
    idlePulse = 1'b1; settle(); idlePulse = 1'b0;
    expectStatus("R7 idle", 9'h100);
  endtask

  task automatic testDisabled();
    writeEn(9'h000);
    busErrPulse = 1'b1; settle(); busErrPulse = 1'b0;
    txReleased = 1'b1; settle();
    rxPending = 1'b1;
    #1 checkEq("R8 irq disabled", int'(irqOut), 0);
    settle();
    expectStatus("R8 disabled events", 0);
    rxPending = 1'b0;
    writeEn(9'h1FF);
    settle();
    expectStatus("R8 no late set", 0);
    txReleased = 1'b0;
    settle();
  endtask

  task automatic testCollision();
    logic [NUM_SRC-1:0] d;
    arbLostPulse = 1'b1; settle(); arbLostPulse = 1'b0;
    busErrPulse = 1'b1;
    readReg(ADDR_STATUS, d);
    busErrPulse = 1'b0;
    checkEq("R11 read returns old word", int'(d), 9'h040);
    expectStatus("R11 event survives clear", 9'h080);
    expectStatus("R9 cleared afterwards", 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testRx();
    testTx();
    testWarn();
    testOverrun();
    testPassive();
    testPulses();
    testDisabled();
    testCollision();
    finishRun();
  end

endmodule